// File: doc/BRIEF.md
# Bulk Erase and Write Command Guard

This block sequences the chip-wide commands of a serial non-volatile memory. It accepts opcodes that an upstream shift-register front end has already decoded, together with a parity-error flag for each command. It decides whether an erase of the whole array or a write of the whole array may begin. Both destructive operations need a two-step entry. An erase-all opcode on its own only arms the guard. A second erase-all launches the erase. A write-all that follows the arming erase-all launches the fill.

A countdown timer stands in for the programming time. While it runs, the block rejects every command. The block also builds an 8-bit status byte. The serial data-out pin is modelled as an enable and a level. While a cycle runs, the pin can show busy by driving low. After the cycle it shows ready by driving high, and it releases when chip select is removed. Busy reporting must be switched on beforehand by its own opcode.

Opcode encoding on `cmdCode`: 4'h2 is erase-all, 4'h1 is write-all, 4'h3 disables busy reporting, 4'h4 enables busy reporting. Every other value is an ordinary command that this block only acknowledges.

Top module: `bulkEraseGuard`

## Requirements
- R1: An erase-all opcode received while the guard is armed pulses `eraseAllGo` for one cycle, in the cycle after the opcode is sampled. A single erase-all only arms the guard and pulses nothing.
- R2: A write-all opcode received while the guard is armed pulses `writeAllGo` for one cycle. A write-all received while disarmed starts nothing and sets the instruction-error bit.
- R3: While the guard is armed, any opcode other than erase-all or write-all disarms it, is discarded and sets the instruction-error bit. A cleanly accepted command clears the instruction-error bit.
- R4: `statusByte[7:5]` always reads 3'b101 and `statusByte[1:0]` always reads 2'b00. Bit 4 is the parity error, bit 3 is the instruction error and bit 2 is busy (1 while a cycle runs).
- R5: A command that arrives with `parityErr` high is discarded, sets status bit 4 and disarms the guard. The next clean command clears bit 4.
- R6: After a launch, `busy` and status bit 2 stay high for exactly BUSY_CYCLES clock cycles, starting in the cycle of the launch pulse.
- R7: A command sampled while busy is rejected. It launches nothing, does not arm the guard and sets the instruction-error bit.
- R8: While busy with reporting enabled (opcode 4'h4), `doutEn` is 1 and `doutVal` is 0. With reporting disabled (opcode 4'h3, the reset state), `doutEn` stays 0 during and after the cycle.
- R9: When a reported cycle ends, `doutEn` is 1 and `doutVal` is 1 until `chipSel` is sampled low. From the next cycle on, `doutEn` is 0.
- R10: After reset, `statusByte` is 8'hA0, `busy`, `doutEn` and both launch pulses are 0, and the guard is disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A decoded opcode is present this cycle |
| cmdCode | input | 4 | Decoded opcode |
| parityErr | input | 1 | Parity check failed for this command |
| chipSel | input | 1 | Chip select, high while the device is selected |
| eraseAllGo | output | 1 | One-cycle launch of a whole-array erase |
| writeAllGo | output | 1 | One-cycle launch of a whole-array write |
| busy | output | 1 | Programming cycle in progress |
| statusByte | output | 8 | Signature, error flags and busy bit |
| doutEn | output | 1 | Data-out driver enable (0 means high impedance) |
| doutVal | output | 1 | Data-out level while enabled |

## Verification
The bench attacks the arming flag from every side. It sends a lone erase-all, a write-all with no arming command, a stray opcode between the two steps, and a parity-failed erase-all. A guard that remembered a broken sequence would launch a bulk operation the user never confirmed twice. It sends an erase-all during a running cycle and a real one after the cycle. A design that let busy-time commands arm the guard would then erase on the first command after the cycle. It counts the busy window cycle by cycle, so an off-by-one timer shows up. It also follows the data-out pin through busy-low, ready-high and the release on chip select, both with reporting enabled and with it disabled.

// File: rtl/bulkGuardPkg.sv
package bulkGuardPkg;

  localparam int unsigned OP_W = 4;

  typedef logic [OP_W-1:0] opcode_t;

  localparam opcode_t OP_WRITE_ALL = 4'h1;
  localparam opcode_t OP_ERASE_ALL = 4'h2;
  localparam opcode_t OP_RPT_OFF   = 4'h3;
  localparam opcode_t OP_RPT_ON    = 4'h4;

  localparam logic [2:0] STATUS_SIG = 3'b101;

  // strobes from the sequencer to the datapath, valid for one cycle
  typedef struct packed {
    logic loadTimer;   // launch a bulk cycle
    logic opIsWrite;   // launched cycle is write-all (else erase-all)
    logic setParity;
    logic clrParity;
    logic setInstr;
    logic clrInstr;
    logic rptOn;
    logic rptOff;
  } guardStrobe_t;

endpackage

// File: rtl/guardCtrl.sv
module guardCtrl
  import bulkGuardPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  opcode_t      cmdCode,
  input  logic         parityErr,
  input  logic         busy,
  output guardStrobe_t strobe
);

  logic armedQ;
  logic armedNext;

  always_comb begin
    strobe    = '0;
    armedNext = armedQ;
    if (cmdValid) begin
      if (busy) begin
        strobe.setInstr = 1'b1;
      end else if (parityErr) begin
        strobe.setParity = 1'b1;
        armedNext        = 1'b0;
      end else begin
        strobe.clrParity = 1'b1;
        if (armedQ) begin
          armedNext = 1'b0;
          unique case (cmdCode)
            OP_ERASE_ALL: begin
              strobe.loadTimer = 1'b1;
              strobe.clrInstr  = 1'b1;
            end
            OP_WRITE_ALL: begin
              strobe.loadTimer = 1'b1;
              strobe.opIsWrite = 1'b1;
              strobe.clrInstr  = 1'b1;
            end
            default: strobe.setInstr = 1'b1;
          endcase
        end else begin
          unique case (cmdCode)
            OP_ERASE_ALL: begin
              armedNext       = 1'b1;
              strobe.clrInstr = 1'b1;
            end
            OP_WRITE_ALL: strobe.setInstr = 1'b1;
            OP_RPT_ON: begin
              strobe.rptOn    = 1'b1;
              strobe.clrInstr = 1'b1;
            end
            OP_RPT_OFF: begin
              strobe.rptOff   = 1'b1;
              strobe.clrInstr = 1'b1;
            end
            default: strobe.clrInstr = 1'b1;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) armedQ <= 1'b0;
    else       armedQ <= armedNext;
  end

  // R7
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && busy) |-> !strobe.loadTimer);

  // R1
  launch_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTimer |-> armedQ);

  // R3
  arm_single_use_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && cmdValid && !busy) |=> !armedQ);

endmodule

// File: rtl/guardData.sv
module guardData
  import bulkGuardPkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 200
) (
  input  logic         clk,
  input  logic         rstN,
  input  guardStrobe_t strobe,
  input  logic         chipSel,
  output logic         busy,
  output logic [7:0]   statusByte,
  output logic         doutEn,
  output logic         doutVal,
  output logic         eraseGo,
  output logic         writeGo
);

  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic parityQ;
  logic instrQ;
  logic rptEnQ;
  logic readyHoldQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ       <= '0;
      parityQ    <= 1'b0;
      instrQ     <= 1'b0;
      rptEnQ     <= 1'b0;
      readyHoldQ <= 1'b0;
      eraseGo    <= 1'b0;
      writeGo    <= 1'b0;
    end else begin
      if (strobe.loadTimer)  cntQ <= CNT_LOAD;
      else if (cntQ != '0)   cntQ <= cntQ - CNT_ONE;

      eraseGo <= strobe.loadTimer && !strobe.opIsWrite;
      writeGo <= strobe.loadTimer &&  strobe.opIsWrite;

      if (strobe.setParity)      parityQ <= 1'b1;
      else if (strobe.clrParity) parityQ <= 1'b0;

      if (strobe.setInstr)       instrQ <= 1'b1;
      else if (strobe.clrInstr)  instrQ <= 1'b0;

      if (strobe.rptOn)          rptEnQ <= 1'b1;
      else if (strobe.rptOff)    rptEnQ <= 1'b0;

      if (strobe.loadTimer || !chipSel)       readyHoldQ <= 1'b0;
      else if (cntQ == CNT_ONE && rptEnQ)     readyHoldQ <= 1'b1;
    end
  end

  assign busy       = (cntQ != '0);
  assign statusByte = {STATUS_SIG, parityQ, instrQ, busy, 2'b00};
  assign doutEn     = (busy && rptEnQ) || readyHoldQ;
  assign doutVal    = readyHoldQ && !busy;

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strobe.loadTimer));

  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.loadTimer) |=> (cntQ == $past(cntQ) - CNT_ONE));

  // R8
  busy_drive_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rptEnQ) |-> (doutEn && !doutVal));

  // R9
  cs_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSel && !busy && !strobe.loadTimer) |=> !doutEn);

endmodule

// File: rtl/bulkEraseGuard.sv
module bulkEraseGuard
  import bulkGuardPkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [3:0] cmdCode,
  input  logic       parityErr,
  input  logic       chipSel,
  output logic       eraseAllGo,
  output logic       writeAllGo,
  output logic       busy,
  output logic [7:0] statusByte,
  output logic       doutEn,
  output logic       doutVal
);

  guardStrobe_t strobe;

  guardCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdCode   (opcode_t'(cmdCode)),
    .parityErr (parityErr),
    .busy      (busy),
    .strobe    (strobe)
  );

  guardData #(.BUSY_CYCLES(BUSY_CYCLES)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .chipSel    (chipSel),
    .busy       (busy),
    .statusByte (statusByte),
    .doutEn     (doutEn),
    .doutVal    (doutVal),
    .eraseGo    (eraseAllGo),
    .writeGo    (writeAllGo)
  );

endmodule

// File: tb/bulkEraseGuard_tb.sv
module bulkEraseGuard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY_N     = 4;
  localparam int NVEC       = 12;

  // {opcode[14:11], parity[10], expErase[9], expWrite[8], expStatus[7:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    {4'h2, 1'b0, 1'b0, 1'b0, 8'hA0},  // R1 lone erase-all only arms
    {4'h2, 1'b0, 1'b1, 1'b0, 8'hA4},  // R1 second erase-all launches
    {4'h2, 1'b0, 1'b0, 1'b0, 8'hA0},  // R2 arm
    {4'h1, 1'b0, 1'b0, 1'b1, 8'hA4},  // R2 write-all launches
    {4'h1, 1'b0, 1'b0, 1'b0, 8'hA8},  // R2 unarmed write-all errors
    {4'h2, 1'b0, 1'b0, 1'b0, 8'hA0},  // R3 arm, clean clears error
    {4'h5, 1'b0, 1'b0, 1'b0, 8'hA8},  // R3 stray opcode disarms
    {4'h2, 1'b0, 1'b0, 1'b0, 8'hA0},  // R3 re-arm only
    {4'h2, 1'b1, 1'b0, 1'b0, 8'hB0},  // R5 parity-failed erase discarded
    {4'h2, 1'b0, 1'b0, 1'b0, 8'hA0},  // R5 clean clears parity, arms only
    {4'h6, 1'b0, 1'b0, 1'b0, 8'hA8},  // R3 stray opcode disarms
    {4'h0, 1'b0, 1'b0, 1'b0, 8'hA0}   // R3 plain opcode accepted
  };

  logic clk = 1'b0;
  logic rstN, cmdValid, parityErr, chipSel;
  logic [3:0] cmdCode;
  logic eraseAllGo, writeAllGo, busy, doutEn, doutVal;
  logic [7:0] statusByte;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bulkEraseGuard #(.BUSY_CYCLES(BUSY_N)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .parityErr(parityErr), .chipSel(chipSel), .eraseAllGo(eraseAllGo),
    .writeAllGo(writeAllGo), .busy(busy), .statusByte(statusByte),
    .doutEn(doutEn), .doutVal(doutVal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one command for one sampling edge; returns at the negedge after it
  task automatic sendCmd(input logic [3:0] op, input logic par);
    @(negedge clk);
    cmdCode = op; parityErr = par; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; parityErr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; parityErr = 1'b0; chipSel = 1'b1; cmdCode = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    check("R10 status", statusByte, 8'hA0);
    check("R10 busy", busy, 0);
    check("R10 doutEn", doutEn, 0);
    check("R10 go pulses", {eraseAllGo, writeAllGo}, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      sendCmd(VEC[i][14:11], VEC[i][10]);
      check($sformatf("R1 eraseGo vec%0d", i), eraseAllGo, VEC[i][9]);
      check($sformatf("R2 writeGo vec%0d", i), writeAllGo, VEC[i][8]);
      check($sformatf("R4 status vec%0d", i), statusByte, VEC[i][7:0]);
      if (VEC[i][9] || VEC[i][8]) idle(BUSY_N);
    end

    // R7 command during busy rejected and does not arm
    sendCmd(4'h2, 1'b0);
    sendCmd(4'h2, 1'b0);
    check("R1 launch before busy test", eraseAllGo, 1);
    sendCmd(4'h2, 1'b0);
    check("R7 no launch while busy", eraseAllGo, 0);
    check("R7 status busy+error", statusByte, 8'hAC);
    idle(BUSY_N);
    check("R7 status after cycle", statusByte, 8'hA8);
    sendCmd(4'h2, 1'b0);
    check("R7 busy-time erase did not arm", eraseAllGo, 0);
    check("R7 status after arming", statusByte, 8'hA0);
    sendCmd(4'h0, 1'b0);

    // R6 busy length, R8 drive low, R9 ready high and release
    sendCmd(4'h4, 1'b0);
    check("R8 doutEn idle before cycle", doutEn, 0);
    sendCmd(4'h2, 1'b0);
    sendCmd(4'h2, 1'b0);
    check("R8 doutEn during busy", doutEn, 1);
    check("R8 doutVal during busy", doutVal, 0);
    begin
      int cnt = 0;
      while (busy && cnt < 100) begin
        cnt++;
        @(negedge clk);
      end
      check("R6 busy length", cnt, BUSY_N);
    end
    check("R9 doutEn ready", doutEn, 1);
    check("R9 doutVal ready", doutVal, 1);
    idle(2);
    check("R9 ready held while selected", {doutEn, doutVal}, 2'b11);
    chipSel = 1'b0;
    @(negedge clk);
    check("R9 release on deselect", doutEn, 0);
    chipSel = 1'b1;
    @(negedge clk);
    check("R9 stays released", doutEn, 0);

    // R8 reporting disabled
    sendCmd(4'h3, 1'b0);
    sendCmd(4'h2, 1'b0);
    sendCmd(4'h2, 1'b0);
    check("R6 busy after launch", busy, 1);
    check("R8 no drive while disabled", doutEn, 0);
    idle(BUSY_N);
    check("R8 no ready drive while disabled", doutEn, 0);
    check("R6 busy cleared", statusByte, 8'hA0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule